// File: doc/BRIEF.md
# Exception Priority Arbiter

This block decides which pending exception the processor should take next. It sees 8 trap request lines and 54 interrupt request lines. Each interrupt line has a 3-bit user priority. Trap lines have fixed levels that sit above every interrupt. Each time the sequencer is ready, the block finds the strongest pending request. If that request's level is strictly above the processor's current level, the block issues a one-cycle take pulse. The pulse carries the winning vector number and the new level, and a one-hot acknowledge goes to the source that won.

Vectors 0 to 7 are the traps and vectors 8 to 61 are interrupts 0 to 53. Only the trap lines set in the `TRAP_USED` mask can request. By default these are traps 0 to 3, and traps 4 to 7 are reserved.

A three-state sequencer paces the grants:
- `ST_IDLE` evaluates the candidate and moves to `ST_TAKE` when it is eligible; otherwise it stays in `ST_IDLE`.
- `ST_TAKE` drives the take pulse and the acknowledge for one cycle, then always moves to `ST_SETTLE`.
- `ST_SETTLE` waits one cycle so the source can withdraw its request and the processor can raise its level, then always returns to `ST_IDLE`.

Top module: `exc_arbiter`

## Requirements
- R1: After reset, `take` is 0, `take_vec` and `take_lvl` are 0, and every acknowledge bit is 0.
- R2: Any requesting, unreserved trap beats every interrupt, including one with priority 7.
- R3: Trap i is given vector i and level 15 - i. When several traps request, the lowest index wins.
- R4: Reserved trap lines (indices 4 to 7 by default) never win and never cause a take.
- R5: Interrupt j is given vector 8 + j and a level equal to its 3-bit priority. The priority field of interrupt j is `irq_prio[3*j+2:3*j]`.
- R6: Among interrupts, a higher user priority wins whatever its index.
- R7: Among interrupts with equal priority, the lower vector number wins.
- R8: An interrupt with priority 0 is never taken.
- R9: A request is taken only when its level is strictly greater than `cpu_lvl`. An equal level is not taken.
- R10: A take rises on the clock edge after the eligible request is sampled and lasts exactly one cycle. During that cycle exactly one acknowledge bit is 1: `trap_ack[v]` for a trap vector v, or `irq_ack[v-8]` for an interrupt vector v. Outside a take, `take_vec` and `take_lvl` read 0 and no acknowledge bit is set.
- R11: After a take, `take` stays low for at least two cycles. A request held continuously is therefore granted every third cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trap_req | input | 8 | Trap request lines, bit i is trap i |
| irq_req | input | 54 | Interrupt request lines, bit j is interrupt j |
| irq_prio | input | 162 | Packed 3-bit priorities, interrupt j at bits 3j+2..3j |
| cpu_lvl | input | 4 | Current processor priority level |
| take | output | 1 | One-cycle exception take pulse |
| take_vec | output | 6 | Winning vector number, 0 outside a take |
| take_lvl | output | 4 | Level of the winner, 0 outside a take |
| trap_ack | output | 8 | One-hot acknowledge to the winning trap |
| irq_ack | output | 54 | One-hot acknowledge to the winning interrupt |

## Verification
A wrong sequencer state shows at the ports within one cycle. Either `take` lasts more than one cycle, or it comes back too soon after a grant, or an acknowledge appears with no take. A wrongly latched candidate shows in the same take cycle as a vector, level or acknowledge bit that differs from the computed winner. A wrong eligibility decision shows as a take that is missing, or one whose level does not exceed the `cpu_lvl` sampled one edge before.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int N_TRAP  = 8;
    localparam int N_IRQ   = 54;
    localparam int PRIO_W  = 3;
    localparam int LVL_W   = 4;
    localparam int VEC_W   = $clog2(N_TRAP + N_IRQ);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_TAKE   = 2'd1,
        ST_SETTLE = 2'd2
    } exc_state_t;
endpackage

// File: rtl/exc_trap_rank.sv
module exc_trap_rank #(
    parameter int                N_TRAP    = 8,
    parameter logic [N_TRAP-1:0] TRAP_USED = 8'h0F,
    parameter int                VEC_W     = 6,
    parameter int                LVL_W     = 4
) (
    input  logic [N_TRAP-1:0] trap_req,
    output logic              hit,
    output logic [VEC_W-1:0]  vec,
    output logic [LVL_W-1:0]  lvl
);
    localparam int TOP_LVL = (1 << LVL_W) - 1;

    // Scan downward so the lowest requesting index is the last one written.
    always_comb begin
        hit = 1'b0;
        vec = '0;
        lvl = '0;
        for (int i = N_TRAP - 1; i >= 0; i--) begin
            if (trap_req[i] && TRAP_USED[i]) begin
                hit = 1'b1;
                vec = VEC_W'(i);
                lvl = LVL_W'(TOP_LVL - i);
            end
        end
    end
endmodule

// File: rtl/exc_irq_rank.sv
module exc_irq_rank #(
    parameter int N_IRQ  = 54,
    parameter int PRIO_W = 3,
    parameter int BASE   = 8,
    parameter int VEC_W  = 6,
    parameter int LVL_W  = 4
) (
    input  logic [N_IRQ-1:0]        irq_req,
    input  logic [N_IRQ*PRIO_W-1:0] irq_prio,
    output logic                    hit,
    output logic [VEC_W-1:0]        vec,
    output logic [LVL_W-1:0]        lvl
);
    logic [PRIO_W-1:0] best_p;

    // Ascending scan with a strict compare: on a tie the earlier index is kept.
    // A priority of 0 never beats the starting value, so it stays disabled.
    always_comb begin
        best_p = '0;
        vec    = '0;
        for (int j = 0; j < N_IRQ; j++) begin
            if (irq_req[j] && (irq_prio[j*PRIO_W +: PRIO_W] > best_p)) begin
                best_p = irq_prio[j*PRIO_W +: PRIO_W];
                vec    = VEC_W'(BASE + j);
            end
        end
        hit = (best_p != '0);
        lvl = LVL_W'(best_p);
    end
endmodule

// File: rtl/exc_seq.sv
module exc_seq
    import exc_pkg::*;
#(
    parameter int VEC_W = 6,
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cand_ok,
    input  logic [VEC_W-1:0] cand_vec,
    input  logic [LVL_W-1:0] cand_lvl,
    output logic             take,
    output logic [VEC_W-1:0] take_vec,
    output logic [LVL_W-1:0] take_lvl
);
    exc_state_t       state, state_nx;
    logic [VEC_W-1:0] vec_q;
    logic [LVL_W-1:0] lvl_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (cand_ok) state_nx = ST_TAKE;
            ST_TAKE:   state_nx = ST_SETTLE;
            ST_SETTLE: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            vec_q <= '0;
            lvl_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && cand_ok) begin
                vec_q <= cand_vec;
                lvl_q <= cand_lvl;
            end
        end
    end

    always_comb begin
        take     = 1'b0;
        take_vec = '0;
        take_lvl = '0;
        unique case (state)
            ST_TAKE: begin
                take     = 1'b1;
                take_vec = vec_q;
                take_lvl = lvl_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
#(
    parameter int                NT        = N_TRAP,
    parameter int                NI        = N_IRQ,
    parameter int                PW        = PRIO_W,
    parameter int                LW        = LVL_W,
    parameter int                VW        = VEC_W,
    parameter logic [NT-1:0]     TRAP_USED = 8'h0F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NT-1:0]    trap_req,
    input  logic [NI-1:0]    irq_req,
    input  logic [NI*PW-1:0] irq_prio,
    input  logic [LW-1:0]    cpu_lvl,
    output logic             take,
    output logic [VW-1:0]    take_vec,
    output logic [LW-1:0]    take_lvl,
    output logic [NT-1:0]    trap_ack,
    output logic [NI-1:0]    irq_ack
);
    logic          t_hit, i_hit, cand_ok;
    logic [VW-1:0] t_vec, i_vec, c_vec;
    logic [LW-1:0] t_lvl, i_lvl, c_lvl;

    exc_trap_rank #(.N_TRAP(NT), .TRAP_USED(TRAP_USED), .VEC_W(VW), .LVL_W(LW)) u_trap (
        .trap_req(trap_req), .hit(t_hit), .vec(t_vec), .lvl(t_lvl)
    );

    exc_irq_rank #(.N_IRQ(NI), .PRIO_W(PW), .BASE(NT), .VEC_W(VW), .LVL_W(LW)) u_irq (
        .irq_req(irq_req), .irq_prio(irq_prio), .hit(i_hit), .vec(i_vec), .lvl(i_lvl)
    );

    // Trap group outranks the interrupt group outright.
    always_comb begin
        c_vec   = t_hit ? t_vec : i_vec;
        c_lvl   = t_hit ? t_lvl : i_lvl;
        cand_ok = (t_hit || i_hit) && (c_lvl > cpu_lvl);
    end

    exc_seq #(.VEC_W(VW), .LVL_W(LW)) u_seq (
        .clk(clk), .rst_n(rst_n), .cand_ok(cand_ok), .cand_vec(c_vec), .cand_lvl(c_lvl),
        .take(take), .take_vec(take_vec), .take_lvl(take_lvl)
    );

    for (genvar g = 0; g < NT; g++) begin : g_tack
        assign trap_ack[g] = take && (take_vec == VW'(g));
    end
    for (genvar g = 0; g < NI; g++) begin : g_iack
        assign irq_ack[g] = take && (take_vec == VW'(NT + g));
    end
endmodule

// File: rtl/exc_arbiter_chk.sv
module exc_arbiter_chk #(
    parameter int            NT        = 8,
    parameter int            NI        = 54,
    parameter int            PW        = 3,
    parameter int            LW        = 4,
    parameter int            VW        = 6,
    parameter logic [NT-1:0] TRAP_USED = 8'h0F
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NT-1:0] trap_req,
    input logic [LW-1:0] cpu_lvl,
    input logic          take,
    input logic [VW-1:0] take_vec,
    input logic [LW-1:0] take_lvl,
    input logic [NT-1:0] trap_ack,
    input logic [NI-1:0] irq_ack
);
    localparam int            TI_W    = $clog2(NT);
    localparam logic [VW-1:0] NT_V    = VW'(NT);
    localparam logic [LW-1:0] TOP_L   = LW'((1 << LW) - 1);
    localparam logic [LW-1:0] IRQ_MAX = LW'((1 << PW) - 1);

    logic [NT+NI-1:0] all_ack;
    assign all_ack = {irq_ack, trap_ack};

    assert_take_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take);
    assert_ack_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ($countones(all_ack) == 1 && all_ack[take_vec]));
    assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !take |-> (all_ack == '0 && take_vec == '0 && take_lvl == '0));
    assert_take_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take ##1 !take);
    assert_above_cpu_R9: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> take_lvl > $past(cpu_lvl));
    assert_trap_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_vec < NT_V) |-> take_lvl == TOP_L - LW'(take_vec));
    assert_no_reserved_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_vec < NT_V) |-> TRAP_USED[take_vec[TI_W-1:0]]);
    assert_trap_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_vec >= NT_V) |-> (($past(trap_req) & TRAP_USED) == '0));
    assert_irq_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_vec >= NT_V) |-> (take_lvl != '0 && take_lvl <= IRQ_MAX));
endmodule

bind exc_arbiter exc_arbiter_chk #(
    .NT(NT), .NI(NI), .PW(PW), .LW(LW), .VW(VW), .TRAP_USED(TRAP_USED)
) u_chk (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .cpu_lvl(cpu_lvl),
    .take(take), .take_vec(take_vec), .take_lvl(take_lvl),
    .trap_ack(trap_ack), .irq_ack(irq_ack)
);

// File: tb/exc_arbiter_test.sv
`timescale 1ns/1ps
module exc_arbiter_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   trap_req = '0;
    logic [53:0]  irq_req = '0;
    logic [161:0] irq_prio = '0;
    logic [3:0]   cpu_lvl = '0;
    logic         take;
    logic [5:0]   take_vec;
    logic [3:0]   take_lvl;
    logic [7:0]   trap_ack;
    logic [53:0]  irq_ack;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    exc_arbiter uut (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .irq_req(irq_req),
        .irq_prio(irq_prio), .cpu_lvl(cpu_lvl), .take(take), .take_vec(take_vec),
        .take_lvl(take_lvl), .trap_ack(trap_ack), .irq_ack(irq_ack)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_inputs();
        trap_req = '0;
        irq_req  = '0;
        irq_prio = '0;
        cpu_lvl  = '0;
    endtask

    task automatic set_irq(input int j, input logic [2:0] p);
        irq_req[j] = 1'b1;
        irq_prio[j*3 +: 3] = p;
    endtask

    // Inputs must be set up by the caller before this; one edge later the take is visible.
    task automatic expect_out(input bit exp_take, input int exp_vec, input int exp_lvl, input string tag);
        logic [61:0] exp_ack;
        @(negedge clk);
        exp_ack = exp_take ? (62'd1 << exp_vec) : '0;
        check(take == exp_take, {tag, " take"}, 64'(take), 64'(exp_take));
        check(take_vec == 6'(exp_take ? exp_vec : 0), {tag, " vec"}, 64'(take_vec), 64'(exp_take ? exp_vec : 0));
        check(take_lvl == 4'(exp_take ? exp_lvl : 0), {tag, " lvl"}, 64'(take_lvl), 64'(exp_take ? exp_lvl : 0));
        check({irq_ack, trap_ack} == exp_ack, {tag, " ack"}, 64'({irq_ack, trap_ack}), 64'(exp_ack));
        clear_inputs();
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check(take == 1'b0, "R1 take", 64'(take), 0);
        check(take_vec == '0 && take_lvl == '0, "R1 vec/lvl", 64'({take_vec, take_lvl}), 0);
        check({irq_ack, trap_ack} == '0, "R1 ack", 64'({irq_ack, trap_ack}), 0);
    endtask

    task automatic t_traps();
        trap_req = 8'b0000_0100;
        expect_out(1, 2, 13, "R3 single trap");
        trap_req = 8'b0000_1010;
        expect_out(1, 1, 14, "R3 lowest trap wins");
        trap_req = 8'b0000_0001;
        expect_out(1, 0, 15, "R3 trap0 level");
    endtask

    task automatic t_trap_over_irq();
        trap_req = 8'b0000_1000;
        set_irq(0, 3'd7);
        expect_out(1, 3, 12, "R2 trap beats prio7");
    endtask

    task automatic t_reserved();
        trap_req = 8'b1010_0000;
        expect_out(0, 0, 0, "R4 reserved only");
        trap_req = 8'b0100_0000;
        set_irq(10, 3'd2);
        expect_out(1, 18, 2, "R4 reserved ignored");
    endtask

    task automatic t_irq_map();
        set_irq(53, 3'd4);
        expect_out(1, 61, 4, "R5 last irq vector");
        set_irq(0, 3'd1);
        expect_out(1, 8, 1, "R5 first irq vector");
    endtask

    task automatic t_irq_prio();
        set_irq(0, 3'd2);
        set_irq(40, 3'd6);
        expect_out(1, 48, 6, "R6 higher prio wins");
    endtask

    task automatic t_irq_tie();
        set_irq(30, 3'd5);
        set_irq(12, 3'd5);
        expect_out(1, 20, 5, "R7 tie lower vector");
    endtask

    task automatic t_prio_zero();
        set_irq(5, 3'd0);
        expect_out(0, 0, 0, "R8 prio0 alone");
        set_irq(5, 3'd0);
        set_irq(50, 3'd1);
        expect_out(1, 58, 1, "R8 prio0 skipped");
    endtask

    task automatic t_cpu_level();
        set_irq(7, 3'd4);
        cpu_lvl = 4'd4;
        expect_out(0, 0, 0, "R9 equal level blocked");
        set_irq(7, 3'd4);
        cpu_lvl = 4'd3;
        expect_out(1, 15, 4, "R9 above level taken");
        trap_req = 8'b0000_1000;
        cpu_lvl = 4'd12;
        expect_out(0, 0, 0, "R9 trap equal blocked");
        trap_req = 8'b0000_0001;
        cpu_lvl = 4'd15;
        expect_out(0, 0, 0, "R9 level15 blocks all");
    endtask

    task automatic t_pulse_gap();
        bit exp_pat [6] = '{1, 0, 0, 1, 0, 0};
        set_irq(20, 3'd3);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check(take == exp_pat[k], "R10 R11 held request cadence", 64'(take), 64'(exp_pat[k]));
        end
        clear_inputs();
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_traps();
        t_trap_over_irq();
        t_reserved();
        t_irq_map();
        t_irq_prio();
        t_irq_tie();
        t_prio_zero();
        t_cpu_level();
        t_pulse_gap();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule